// File: doc/BRIEF.md
# Push-Button Display Source Selector

This block chooses which of four 8-bit measurement values reaches a vehicle's overhead display. The four inputs are cabin temperature, average fuel economy, instantaneous fuel economy and remaining range. A two-bit selection register decides which input is shown. Each press of a single push button moves that register one step forward, and after the last source it returns to the first.

The button input is assumed to be debounced and synchronous to the clock. The block looks for a rising edge on it, so one press moves the selection once no matter how long the button stays down. The data path is eight single-bit four-way multiplexers that share one pair of select lines. Because the output depends only on the current select and the current inputs, a change on the shown source reaches the display in the same cycle.

Top module: `disp_src_sel`

## Requirements
- R1: After reset the selection output is 2'b00 (temperature) and the display shows the temperature input.
- R2: Selection code 0 routes the temperature input, code 1 average economy, code 2 instantaneous economy and code 3 remaining range. The high bit of the code is sel_o[1].
- R3: A 0-to-1 transition of btn_i, sampled at a clock edge, increments the selection by one at that same edge.
- R4: From code 3 the selection wraps to code 0.
- R5: While btn_i stays high or stays low, the selection does not change.
- R6: The display output equals the selected input combinationally, with no cycle of delay when that input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| btn_i | input | 1 | Debounced button level |
| temp_i | input | 8 | Temperature value (code 0) |
| avg_econ_i | input | 8 | Average economy value (code 1) |
| inst_econ_i | input | 8 | Instantaneous economy value (code 2) |
| range_i | input | 8 | Remaining range value (code 3) |
| disp_o | output | 8 | Value shown on the display |
| sel_o | output | 2 | Current selection code |

## Verification
The only state is the selection register and the delayed copy of the button. A wrong selection value appears on sel_o at once and changes disp_o from the very next sample. A wrong button-history bit shows up one edge later, as a missing step or as an extra step while the button is held. The bench keeps a model of the selection alongside the design and compares both outputs after every cycle. Long holds, back-to-back presses and repeated wraps are mixed into the stimulus.

// File: rtl/disp_src_sel_pkg.sv
package disp_src_sel_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned N_SRC  = 4;
    localparam int unsigned SEL_W  = $clog2(N_SRC);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             btn;
    } sel_state_t;
endpackage

// File: rtl/disp_src_sel_step.sv
module disp_src_sel_step
    import disp_src_sel_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             btn_i,
    output logic [SEL_W-1:0] sel_o
);
    sel_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.btn = btn_i;
        if (btn_i && !st_q.btn) begin
            if (st_q.sel == SEL_W'(N_SRC - 1)) begin
                st_d.sel = '0;
            end else begin
                st_d.sel = st_q.sel + SEL_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{sel: '0, btn: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o = st_q.sel;
endmodule

// File: rtl/disp_src_sel_mux.sv
module disp_src_sel_mux
    import disp_src_sel_pkg::*;
(
    input  logic [SEL_W-1:0]              sel_i,
    input  logic [N_SRC-1:0][DATA_W-1:0]  src_i,
    output logic [DATA_W-1:0]             out_o
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic [N_SRC-1:0] col;
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            assign col[s] = src_i[s][b];
        end
        assign out_o[b] = col[sel_i];
    end
endmodule

// File: rtl/disp_src_sel.sv
module disp_src_sel
    import disp_src_sel_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              btn_i,
    input  logic [DATA_W-1:0] temp_i,
    input  logic [DATA_W-1:0] avg_econ_i,
    input  logic [DATA_W-1:0] inst_econ_i,
    input  logic [DATA_W-1:0] range_i,
    output logic [DATA_W-1:0] disp_o,
    output logic [SEL_W-1:0]  sel_o
);
    logic [N_SRC-1:0][DATA_W-1:0] srcs;
    logic [SEL_W-1:0]             sel;

    assign srcs[0] = temp_i;
    assign srcs[1] = avg_econ_i;
    assign srcs[2] = inst_econ_i;
    assign srcs[3] = range_i;

    disp_src_sel_step u_step (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .btn_i  (btn_i),
        .sel_o  (sel)
    );

    disp_src_sel_mux u_mux (
        .sel_i (sel),
        .src_i (srcs),
        .out_o (disp_o)
    );

    assign sel_o = sel;
endmodule

// File: rtl/disp_src_sel_chk.sv
module disp_src_sel_chk
    import disp_src_sel_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              btn_i,
    input logic [DATA_W-1:0] temp_i,
    input logic [DATA_W-1:0] avg_econ_i,
    input logic [DATA_W-1:0] inst_econ_i,
    input logic [DATA_W-1:0] range_i,
    input logic [DATA_W-1:0] disp_o,
    input logic [SEL_W-1:0]  sel_o
);
    logic seen_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni) seen_q <= 1'b0;
        else         seen_q <= 1'b1;
    end

    p_reset_sel_r1: assert property (@(posedge clk_i)
        !rst_ni |=> sel_o == '0);

    p_route_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        disp_o == (sel_o == 2'd0 ? temp_i : sel_o == 2'd1 ? avg_econ_i :
                   sel_o == 2'd2 ? inst_econ_i : range_i));

    p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && btn_i && !$past(btn_i) && $past(rst_ni) && sel_o != 2'd3)
            |=> sel_o == $past(sel_o) + 2'd1);

    p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && btn_i && !$past(btn_i) && $past(rst_ni) && sel_o == 2'd3)
            |=> sel_o == 2'd0);

    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && $past(rst_ni) && btn_i == $past(btn_i)) |=> $stable(sel_o));
endmodule

bind disp_src_sel disp_src_sel_chk u_chk (.*);

// File: tb/disp_src_sel_tb_top.sv
module disp_src_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn = 1'b0;
    logic [7:0] t = '0, a = '0, n = '0, r = '0;
    logic [7:0] disp;
    logic [1:0] sel;
    int errors = 0, checks = 0;
    logic [1:0] m_sel;
    logic       m_btn;

    always #5 clk = ~clk;

    disp_src_sel dut_i (.clk_i(clk), .rst_ni(rst_n), .btn_i(btn),
        .temp_i(t), .avg_econ_i(a), .inst_econ_i(n), .range_i(r),
        .disp_o(disp), .sel_o(sel));

    function automatic logic [7:0] exp_disp(logic [1:0] s);
        case (s)
            2'd0: return t;
            2'd1: return a;
            2'd2: return n;
            default: return r;
        endcase
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // one clock with model update; button held high through reset counts as no edge
    task automatic cyc(logic b, string req);
        btn = b;
        @(posedge clk);
        if (b && !m_btn) m_sel = m_sel + 2'd1;
        m_btn = b;
        #2;
        chk(req, {14'd0, sel}, {14'd0, m_sel});
        chk("R2", {8'd0, disp}, {8'd0, exp_disp(m_sel)});
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        t = 8'h11; a = 8'h22; n = 8'h33; r = 8'h44;
        btn = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk("R1", {14'd0, sel}, 16'd0);
        chk("R1", {8'd0, disp}, 16'h0011);
        rst_n = 1'b1;
        m_sel = 2'd0; m_btn = 1'b1;
        cyc(1'b1, "R5");         // held from reset: no step
        cyc(1'b0, "R5");
        for (int i = 0; i < 4; i++) begin
            cyc(1'b1, i == 3 ? "R4" : "R3");
            chk("R2", {8'd0, disp}, {8'd0, exp_disp(m_sel)});
            cyc(1'b0, "R5");
        end
        // long hold
        cyc(1'b1, "R3");
        repeat (10) cyc(1'b1, "R5");
        cyc(1'b0, "R5");
        // R6 combinational follow
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            t = 8'($urandom); a = 8'($urandom); n = 8'($urandom); r = 8'($urandom);
            #1;
            chk("R6", {8'd0, disp}, {8'd0, exp_disp(m_sel)});
            cyc(1'b1, "R3");
            cyc(1'b0, "R5");
        end
        // random phase
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if ($urandom_range(3) == 0) begin
                t = 8'($urandom); a = 8'($urandom); n = 8'($urandom); r = 8'($urandom);
            end
            cyc(1'($urandom_range(1)), "R3");
        end
        // reset mid-run
        cyc(1'b1, "R3");
        rst_n = 1'b0; btn = 1'b0;
        @(posedge clk); #2;
        chk("R1", {14'd0, sel}, 16'd0);
        chk("R1", {8'd0, disp}, {8'd0, t});
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule